// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block generates the external bus timing for a small 8-bit processor with a 16-bit address. The high address byte has its own outputs. The low address byte and the data share one multiplexed AD bus, and an address-latch strobe tells an external latch when to capture the low byte. The core places one request at a time on a request port. A request gives a cycle kind, an address, write data and, for opcode fetches, a length. The block runs the bus cycle one T-state per clock period. It returns the byte it read and a one-period done pulse.

The kind of cycle is made visible to the outside world in three ways: the three status outputs, the placement of the read and write strobes across the T-states, and the length of the cycle. Memory read and memory write each take three T-states. An opcode fetch takes four to six. All state changes happen on the falling clock edge, so every output is stable across the rising edge.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and whenever no cycle is running: rd_no=1, wr_no=1, ale_o=0, ad_oe_o=0, done_o=0, io_m_no=0, s1_o=0, s0_o=0, and req_ready_o=1.
- R2: T1 is the first T-state of every cycle. During T1, ale_o is high for exactly that one T-state, addr_hi_o carries address bits 15..8, and ad_o carries address bits 7..0 with ad_oe_o=1. addr_hi_o keeps the address for the whole cycle.
- R3: For every T-state of a cycle, io_m_no is 0 and {s1_o,s0_o} encodes req_kind_i. The kind codes are: 2'b00 opcode fetch gives 11, 2'b01 memory read gives 10, 2'b10 memory write gives 01, and 2'b11 is handled as a memory read and gives 10.
- R4: In read-type cycles (fetch and read), rd_no is low in T2 and T3 only, ad_oe_o is 0 from T2 to the end of the cycle, and wr_no stays high.
- R5: ad_oe_o is never high while rd_no is low, and rd_no and wr_no are never low together.
- R6: A cycle lasts 3 T-states for a read or a write. A fetch lasts 4+N T-states, where N is req_flen_i, and a value of 3 is treated as 2. After T3, rd_no=1, wr_no=1 and ad_oe_o=0. done_o is high during the last T-state only.
- R7: In read-type cycles, the byte on ad_i at the falling edge that ends T3 is stored and appears on rdata_o. rdata_o keeps that value until the next read-type capture, including across write cycles.
- R8: In a write cycle, ad_o carries the write data with ad_oe_o=1 during T2 and T3, and wr_no is low in exactly those two T-states. ad_o keeps the write data after the cycle until the next T1, so it is still valid when wr_no rises.
- R9: A request is taken only at a falling edge where req_ready_o=1 and req_valid_i=1. The request inputs are ignored while a cycle runs.
- R10: State changes happen on the falling clock edge. A request presented before a falling edge starts T1 at that edge, and the outputs do not change at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 read |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write data |
| req_flen_i | input | 2 | Extra fetch T-states beyond four (0..2) |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| done_o | output | 1 | High during the last T-state of a cycle |
| rdata_o | output | 8 | Last byte read or fetched |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Multiplexed address/data output |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 8 | Multiplexed bus input |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_no | output | 1 | I/O-versus-memory status, 0 for memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |

## Verification
A request set up just after a rising edge is taken at the next falling edge. ale_o is therefore due at the rising edge half a period later, and each following T-state is due one period after that. The monitor samples every output at rising edges, where nothing moves. It rebuilds the T-state count from ale_o and compares every strobe, status bit and AD value against the item at the front of the scoreboard queue for that count. Read data and written memory are settled when the falling edge ends the last T-state, so their checks wait for the rising edge after the one where done_o was seen.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RDALT = 2'b11
  } kind_e;

  localparam int unsigned ADDR_PH   = 1;  // T-state carrying low address
  localparam int unsigned DATA_LAST = 3;  // last data-phase T-state
  localparam int unsigned BASE_FLEN = 4;  // shortest fetch
endpackage

// File: rtl/bcs_tstate_ctrl.sv
module bcs_tstate_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned EXTRA_MAX = 2,
  localparam int unsigned FLEN_W = $clog2(EXTRA_MAX + 1),
  localparam int unsigned CW     = $clog2(BASE_FLEN + EXTRA_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [FLEN_W-1:0] req_flen_i,
  output logic              accept_o,
  output logic              idle_o,
  output logic              last_o,
  output logic [CW-1:0]     tcnt_o,
  output kind_e             kind_o
);
  logic [CW-1:0] tcnt_q, last_q, fetch_last;

  always_comb begin
    if (int'(req_flen_i) > EXTRA_MAX) fetch_last = CW'(BASE_FLEN + EXTRA_MAX);
    else                              fetch_last = CW'(BASE_FLEN) + CW'(req_flen_i);
  end

  assign idle_o   = (tcnt_q == '0);
  assign accept_o = idle_o && req_valid_i;
  assign last_o   = !idle_o && (tcnt_q == last_q);
  assign tcnt_o   = tcnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      last_q <= CW'(DATA_LAST);
      kind_o <= KIND_FETCH;
    end else if (accept_o) begin
      tcnt_q <= CW'(ADDR_PH);
      kind_o <= kind_e'(req_kind_i);
      last_q <= (kind_e'(req_kind_i) == KIND_FETCH) ? fetch_last : CW'(DATA_LAST);
    end else if (last_o) begin
      tcnt_q <= '0;
    end else if (!idle_o) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  // R6
  tstate_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !last_o) |=> (tcnt_q == $past(tcnt_q) + 1'b1));
  // R6
  cycle_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> idle_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !last_o) |=> $stable(kind_o));
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tcnt_i,
  input  kind_e         kind_i,
  input  logic          last_i,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_m_no,
  output logic          s1_o,
  output logic          s0_o,
  output logic          done_o
);
  logic active, data_ph, is_wr;

  assign active  = (tcnt_i != '0);
  assign data_ph = (tcnt_i > CW'(ADDR_PH)) && (tcnt_i <= CW'(DATA_LAST));
  assign is_wr   = (kind_i == KIND_WRITE);

  assign ale_o   = (tcnt_i == CW'(ADDR_PH));
  assign rd_no   = !(data_ph && !is_wr);
  assign wr_no   = !(data_ph && is_wr);
  assign io_m_no = 1'b0;  // memory cycles only
  assign s1_o    = active && !is_wr;
  assign s0_o    = active && (is_wr || kind_i == KIND_FETCH);
  assign done_o  = last_i;

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R4
  rd_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> $past(ale_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/bcs_data_path.sv
module bcs_data_path
  import bcs_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [CW-1:0] tcnt_i,
  input  kind_e         kind_i,
  input  logic [DW-1:0] ad_i,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          addr_ph, data_ph, is_wr, capture;

  assign addr_ph = (tcnt_i == CW'(ADDR_PH));
  assign data_ph = (tcnt_i > CW'(ADDR_PH)) && (tcnt_i <= CW'(DATA_LAST));
  assign is_wr   = (kind_i == KIND_WRITE);
  assign capture = (tcnt_i == CW'(DATA_LAST)) && !is_wr;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_o <= ad_i;
    end
  end

  assign addr_hi_o = addr_q[AW-1:DW];
  // write data stays on AD past the rising WR strobe
  assign ad_o      = addr_ph ? addr_q[DW-1:0] : wdata_q;
  assign ad_oe_o   = addr_ph || (data_ph && is_wr);

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(rdata_o));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tcnt_i != '0 && !accept_i) |=> (tcnt_i == '0 || $stable(addr_hi_o)));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned EXTRA_MAX = 2,
  localparam int unsigned FLEN_W = $clog2(EXTRA_MAX + 1),
  localparam int unsigned CW     = $clog2(BASE_FLEN + EXTRA_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [FLEN_W-1:0] req_flen_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic [AW-DW-1:0]  addr_hi_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_no,
  output logic              s1_o,
  output logic              s0_o
);
  logic          accept, last;
  logic [CW-1:0] tcnt;
  kind_e         kind;

  bcs_tstate_ctrl #(.EXTRA_MAX(EXTRA_MAX)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_flen_i  (req_flen_i),
    .accept_o    (accept),
    .idle_o      (req_ready_o),
    .last_o      (last),
    .tcnt_o      (tcnt),
    .kind_o      (kind)
  );

  bcs_strobe_gen #(.CW(CW)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tcnt_i  (tcnt),
    .kind_i  (kind),
    .last_i  (last),
    .ale_o   (ale_o),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .io_m_no (io_m_no),
    .s1_o    (s1_o),
    .s0_o    (s0_o),
    .done_o  (done_o)
  );

  bcs_data_path #(.AW(AW), .DW(DW), .CW(CW)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .tcnt_i      (tcnt),
    .kind_i      (kind),
    .ad_i        (ad_i),
    .addr_hi_o   (addr_hi_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .rdata_o     (rdata_o)
  );

  // R5
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ad_oe_o && !rd_no));
  // R8
  wr_drives_ad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rd_no && wr_no && !ale_o && !ad_oe_o && !done_o));
endmodule

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    int          len;
    logic [7:0]  exp_rd;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [1:0]  req_flen_i = '0;
  logic        req_ready_o, done_o, ad_oe_o, ale_o, rd_no, wr_no, io_m_no, s1_o, s0_o;
  logic [7:0]  rdata_o, addr_hi_o, ad_o, ad_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  bus_cycle_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_flen_i(req_flen_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o), .addr_hi_o(addr_hi_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ale_o(ale_o), .rd_no(rd_no),
    .wr_no(wr_no), .io_m_no(io_m_no), .s1_o(s1_o), .s0_o(s0_o)
  );

  // memory model
  logic [7:0]  mem    [0:255];
  logic [7:0]  shadow [0:255];
  logic [15:0] pend_a = '0, lat_a = '0;
  bit          mem_armed = 0;

  always @(posedge clk_i) if (ale_o) pend_a = {addr_hi_o, ad_o};
  always @(negedge ale_o) lat_a = pend_a;
  always @(posedge wr_no) if (mem_armed) mem[lat_a[7:0]] = ad_o;
  assign ad_i = !rd_no ? mem[lat_a[7:0]] : 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  item_t q[$];

  task automatic do_req(input logic [1:0] kind, input logic [15:0] addr,
                        input logic [7:0] wdata, input logic [1:0] flen, input bit junk);
    item_t it;
    @(posedge clk_i);
    while (!req_ready_o) @(posedge clk_i);
    it.kind  = kind;
    it.addr  = addr;
    it.wdata = wdata;
    it.len   = (kind == 2'b00) ? 4 + ((flen > 2) ? 2 : int'(flen)) : 3;
    it.exp_rd = shadow[addr[7:0]];
    if (kind == 2'b10) shadow[addr[7:0]] = wdata;
    q.push_back(it);
    req_valid_i = 1'b1; req_kind_i = kind; req_addr_i = addr;
    req_wdata_i = wdata; req_flen_i = flen;
    #1;
    // R10: nothing moves at the rising edge
    chk(ale_o == 1'b0, "R10 ale before falling edge", 32'(ale_o), 32'd0);
    @(posedge clk_i);
    chk(ale_o == 1'b1, "R10 T1 starts at falling edge", 32'(ale_o), 32'd1);
    if (junk) begin
      // R9: request during a busy cycle must be ignored
      req_kind_i = ~kind; req_addr_i = ~addr; req_wdata_i = ~wdata; req_flen_i = 2'd0;
      @(posedge clk_i);
    end
    req_valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  item_t cur;
  int    t = 0;
  bit    post = 0;
  logic [7:0] last_rd = '0;

  always @(posedge clk_i) begin
    if (rst_ni && mem_armed) begin
      if (post) begin
        post = 0;
        if (cur.kind != 2'b10) begin
          chk(rdata_o == cur.exp_rd, "R7 read data", 32'(rdata_o), 32'(cur.exp_rd));
          last_rd = cur.exp_rd;
        end else begin
          chk(mem[cur.addr[7:0]] == cur.wdata, "R8 memory written", 32'(mem[cur.addr[7:0]]), 32'(cur.wdata));
          chk(rdata_o == last_rd, "R7 rdata held over write", 32'(rdata_o), 32'(last_rd));
          chk(ad_o == cur.wdata, "R8 ad holds wdata after cycle", 32'(ad_o), 32'(cur.wdata));
        end
      end
      if (ale_o) begin
        chk(t == 0, "R2 ale only at cycle start", 32'(t), 32'd0);
        chk(q.size() > 0, "R9 unexpected cycle", 32'(q.size()), 32'd1);
        if (q.size() > 0) cur = q.pop_front();
        t = 1;
      end else if (t != 0) t++;

      if (t == 0) begin
        chk({rd_no, wr_no, ad_oe_o, done_o, ale_o, io_m_no, s1_o, s0_o, req_ready_o} == 9'b110000001,
            "R1 idle bus", 32'({rd_no, wr_no, ad_oe_o, done_o, ale_o, io_m_no, s1_o, s0_o, req_ready_o}),
            32'b110000001);
      end else begin
        logic [2:0] est;
        est = {1'b0, cur.kind != 2'b10, cur.kind == 2'b00 || cur.kind == 2'b10};
        chk({io_m_no, s1_o, s0_o} == est, "R3 status", 32'({io_m_no, s1_o, s0_o}), 32'(est));
        chk(addr_hi_o == cur.addr[15:8], "R2 high address", 32'(addr_hi_o), 32'(cur.addr[15:8]));
        if (t == 1) begin
          chk({ad_oe_o, ad_o} == {1'b1, cur.addr[7:0]}, "R2 low address on AD",
              32'({ad_oe_o, ad_o}), 32'({1'b1, cur.addr[7:0]}));
          chk({rd_no, wr_no} == 2'b11, "R4 no strobe in T1", 32'({rd_no, wr_no}), 32'd3);
        end else if (t <= 3) begin
          if (cur.kind == 2'b10) begin
            chk({wr_no, rd_no, ad_oe_o} == 3'b011, "R8 write strobes", 32'({wr_no, rd_no, ad_oe_o}), 32'b011);
            chk(ad_o == cur.wdata, "R8 write data on AD", 32'(ad_o), 32'(cur.wdata));
          end else begin
            chk({rd_no, wr_no, ad_oe_o} == 3'b010, "R4 read strobes", 32'({rd_no, wr_no, ad_oe_o}), 32'b010);
          end
        end else begin
          chk({rd_no, wr_no, ad_oe_o, ale_o} == 4'b1100, "R6 quiet after T3",
              32'({rd_no, wr_no, ad_oe_o, ale_o}), 32'b1100);
        end
        chk(done_o == (t == cur.len), "R6 done placement", 32'(done_o), 32'(t == cur.len));
        chk(!(ad_oe_o && !rd_no), "R5 no AD contention", 32'({ad_oe_o, rd_no}), 32'd0);
        if (done_o || t > cur.len) begin
          post = 1;
          t = 0;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 29 + 7);
      shadow[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(posedge clk_i);
    #1;
    // R1: state during reset
    chk({rd_no, wr_no, ale_o, ad_oe_o, done_o, req_ready_o} == 6'b110001, "R1 reset state",
        32'({rd_no, wr_no, ale_o, ad_oe_o, done_o, req_ready_o}), 32'b110001);
    rst_ni = 1'b1;
    mem_armed = 1;
    repeat (2) @(posedge clk_i);
    // R6: fetch lengths, flen 3 clamps to 2
    do_req(2'b00, 16'h1234, 8'h00, 2'd0, 0);
    do_req(2'b00, 16'h0041, 8'h00, 2'd1, 0);
    do_req(2'b00, 16'hFF80, 8'h00, 2'd2, 0);
    do_req(2'b00, 16'h7A7A, 8'h00, 2'd3, 0);
    // R4 R7 reads, incl. kind 11
    do_req(2'b01, 16'hABCD, 8'h00, 2'd0, 0);
    do_req(2'b11, 16'h0002, 8'h00, 2'd2, 0);
    // R8 write, then read back and fetch back
    do_req(2'b10, 16'h5510, 8'h3C, 2'd0, 0);
    do_req(2'b01, 16'h5510, 8'h00, 2'd0, 0);
    do_req(2'b10, 16'h0000, 8'hFF, 2'd1, 1);   // R9 junk during cycle
    do_req(2'b00, 16'h8800, 8'h00, 2'd1, 1);   // R9 junk during fetch
    do_req(2'b01, 16'h0000, 8'h00, 2'd0, 0);
    do_req(2'b10, 16'hFFFF, 8'h5A, 2'd0, 0);
    do_req(2'b10, 16'h01FF, 8'hA5, 2'd0, 0);
    do_req(2'b00, 16'h02FF, 8'h00, 2'd0, 0);
    repeat (12) @(posedge clk_i);
    chk(q.size() == 0, "R9 all requests served", 32'(q.size()), 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule